// File: doc/BRIEF.md
# If-Then Conditional Slot Sequencer

This block lives in an instruction decode stage and follows a predicated group of up to four instructions. A group-opening instruction hands over a base condition code, a slot count and a then/else mask. For each instruction issued after that, the sequencer reports whether the instruction falls inside the group. It also gives the condition that applies to that slot: the base code for a then slot, or the base code with its sense flipped for an else slot. Finally it reports whether that condition holds against the N, Z, C and V flags present in the same cycle.

Decode uses the execute-enable output to let the instruction commit or to squash it. Squashing takes the place of a branch, so the pipeline never pays a redirect penalty. The group closes on its own after the last slot has been issued. A second opening instruction that arrives while a group is still open raises a one-cycle error pulse and replaces the old group.

Top module: `cond_slot_seq`

## Requirements
- R1: A start with `it_count` = L-1 (L from 1 to 4) makes `in_block` high from the next cycle until exactly L issue strobes have been taken, and `in_block` is low after the cycle of the L-th issue.
- R2: The first slot of a group always reports `eff_cond` equal to the base code given at start, whatever the mask holds.
- R3: Slot k (k = 2..4) uses mask bit `it_pattern[k-2]`. Bit value 0 means then and reports the base code. Bit value 1 means else and reports the base code with bit 0 inverted.
- R4: The condition codes are 0 EQ (Z=1), 1 NE (Z=0), 2 GE (N==V), 3 LT (N!=V), 4 GT (Z=0 and N==V), 5 LE (Z=1 or N!=V), 6 CS (C=1) and 7 CC (C=0). Inside a group, `exec_en` equals the truth of `eff_cond` under these rules.
- R5: Outside a group, `exec_en` is 1 and `nest_err` is 0.
- R6: Flags are evaluated combinationally in the cycle of each slot, so a flag change partway through a group changes the result for later slots.
- R7: A cycle without `issue` leaves the slot position unchanged. An `issue` outside a group has no effect.
- R8: A start while a group is open drives `nest_err` high in that cycle. The old group is dropped and the new one begins at its first slot.
- R9: Synchronous active-low reset closes any group: after reset `in_block` is 0 and `exec_en` is 1.
- R10: A start that shares a cycle with `issue` takes priority. That issue is the opening instruction and does not consume a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| it_start | input | 1 | Group-opening instruction strobe |
| it_cond | input | 3 | Base condition code (R4 encoding) |
| it_count | input | $clog2(MAX_SLOTS) | Slot count minus one |
| it_pattern | input | MAX_SLOTS-1 | Then/else mask for slots 2 and up, 1 = else |
| issue | input | 1 | An instruction issues this cycle |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| in_block | output | 1 | The current instruction is inside a group |
| exec_en | output | 1 | Allow the current instruction to commit |
| eff_cond | output | 3 | Condition code applied to the current slot |
| nest_err | output | 1 | Start arrived while a group was open |

## Verification
The main function is driven with four-slot groups whose masks are then-then-else-else and alternating, so that a slot-to-mask-bit misindex shows up. It is also driven with single-slot groups over every code and all sixteen flag values, which separates each condition rule from its inverse. Mid-group flag flips, idle gaps between issues, and issue pulses with no group open show whether flags are sampled per slot and whether the position moves only on issue. Nested starts, start coinciding with issue, reset in mid-group and long random traffic are compared cycle by cycle against a behavioural model.

// File: rtl/cond_seq_pkg.sv
// Shared types for the conditional slot sequencer.
// Assumes condition codes come in inverse pairs that differ only in bit 0.
package cond_seq_pkg;
    localparam int COND_W = 3;

    typedef enum logic [COND_W-1:0] {
        CC_EQ = 3'd0,
        CC_NE = 3'd1,
        CC_GE = 3'd2,
        CC_LT = 3'd3,
        CC_GT = 3'd4,
        CC_LE = 3'd5,
        CC_CS = 3'd6,
        CC_CC = 3'd7
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // Opposite sense of a condition: toggle the pair-select bit.
    function automatic logic [COND_W-1:0] cond_invert(input logic [COND_W-1:0] c);
        return c ^ {{(COND_W-1){1'b0}}, 1'b1};
    endfunction
endpackage

// File: rtl/cond_eval.sv
// Evaluates one condition code against the status flags.
// Purely combinational; assumes the flags are valid in the cycle of use.
module cond_eval
    import cond_seq_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  flags_t            flags_i,
    output logic              pass_o
);
    // Decode the code into its flag test.
    always_comb begin
        unique case (cond_e'(cond_i))
            CC_EQ:   pass_o = flags_i.z;
            CC_NE:   pass_o = !flags_i.z;
            CC_GE:   pass_o = (flags_i.n == flags_i.v);
            CC_LT:   pass_o = (flags_i.n != flags_i.v);
            CC_GT:   pass_o = !flags_i.z && (flags_i.n == flags_i.v);
            CC_LE:   pass_o = flags_i.z || (flags_i.n != flags_i.v);
            CC_CS:   pass_o = flags_i.c;
            default: pass_o = !flags_i.c;
        endcase
    end
endmodule

// File: rtl/slot_tracker.sv
// Holds the open group: base code, last slot index, else mask and position.
// Assumes MAX_SLOTS is a power of two so the count field covers 1..MAX_SLOTS.
module slot_tracker
    import cond_seq_pkg::*;
#(
    parameter int MAX_SLOTS = 4,
    localparam int SW = $clog2(MAX_SLOTS),
    localparam int PW = MAX_SLOTS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COND_W-1:0] base_i,
    input  logic [SW-1:0]     last_i,
    input  logic [PW-1:0]     pat_i,
    input  logic              issue_i,
    output logic              active_o,
    output logic              else_o,
    output logic [COND_W-1:0] base_o,
    output logic              nest_o
);
    logic              active_q;
    logic [SW-1:0]     cnt_q;
    logic [SW-1:0]     last_q;
    logic [PW-1:0]     pat_q;
    logic [COND_W-1:0] base_q;
    logic [MAX_SLOTS-1:0] pat_ext;
    logic [MAX_SLOTS-1:0] hit;

    // Load on start, step on issue, close after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            last_q   <= '0;
            pat_q    <= '0;
            base_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            last_q   <= last_i;
            pat_q    <= pat_i;
            base_q   <= base_i;
        end else if (active_q && issue_i) begin
            if (cnt_q == last_q) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + SW'(1);
            end
        end
    end

    // Slot 0 is always a then slot; mask bits cover the later slots.
    assign pat_ext = {pat_q, 1'b0};

    // One selector per slot picks that slot's then/else bit.
    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_slot
        assign hit[g] = (cnt_q == SW'(g)) && pat_ext[g];
    end

    assign else_o   = |hit;
    assign active_o = active_q;
    assign base_o   = base_q;
    assign nest_o   = start_i && active_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q <= last_q)); // R1
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && issue_i && !start_i && cnt_q == last_q) |=> !active_q); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !issue_i && !start_i) |=> (active_q && $stable(cnt_q))); // R7
    AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (active_q && cnt_q == '0)); // R10
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !active_q); // R9
endmodule

// File: rtl/cond_slot_seq.sv
// Top of the conditional slot sequencer: tracks an open group, forms the
// slot's effective condition and gates execution on the live flags.
// Assumes one issue strobe per decoded instruction and that the opening
// instruction's own issue coincides with it_start.
module cond_slot_seq
    import cond_seq_pkg::*;
#(
    parameter int MAX_SLOTS = 4,
    localparam int SW = $clog2(MAX_SLOTS),
    localparam int PW = MAX_SLOTS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              it_start,
    input  logic [2:0]        it_cond,
    input  logic [SW-1:0]     it_count,
    input  logic [PW-1:0]     it_pattern,
    input  logic              issue,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_v,
    output logic              in_block,
    output logic              exec_en,
    output logic [2:0]        eff_cond,
    output logic              nest_err
);
    logic              active;
    logic              slot_else;
    logic [COND_W-1:0] base;
    logic              pass;
    flags_t            flags;

    assign flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

    slot_tracker #(.MAX_SLOTS(MAX_SLOTS)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (it_start),
        .base_i   (it_cond),
        .last_i   (it_count),
        .pat_i    (it_pattern),
        .issue_i  (issue),
        .active_o (active),
        .else_o   (slot_else),
        .base_o   (base),
        .nest_o   (nest_err)
    );

    // Effective condition: base for then slots, inverse for else slots.
    always_comb begin
        eff_cond = slot_else ? cond_invert(base) : base;
    end

    cond_eval u_eval (
        .cond_i  (eff_cond),
        .flags_i (flags),
        .pass_o  (pass)
    );

    // Outside a group every instruction runs unconditionally.
    always_comb begin
        exec_en = !active || pass;
    end

    assign in_block = active;

    AST_FIRST_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        it_start |=> (in_block && eff_cond == $past(it_cond))); // R2
    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_block |-> (exec_en && !nest_err)); // R5
    AST_NEST_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
        nest_err |=> (in_block && eff_cond == $past(it_cond))); // R8
endmodule

// File: tb/cond_slot_seq_tb.sv
module cond_slot_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       it_start = 1'b0;
    logic [2:0] it_cond = '0;
    logic [1:0] it_count = '0;
    logic [2:0] it_pattern = '0;
    logic       issue = 1'b0;
    logic       flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
    logic       in_block, exec_en, nest_err;
    logic [2:0] eff_cond;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Behavioural reference state
    bit     m_active = 1'b0;
    int     m_pos = 0;
    int     m_len = 0;
    int     m_cond = 0;
    bit [2:0] m_pat = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_slot_seq u_dut (
        .clk(clk), .rst_n(rst_n), .it_start(it_start), .it_cond(it_cond),
        .it_count(it_count), .it_pattern(it_pattern), .issue(issue),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .in_block(in_block), .exec_en(exec_en), .eff_cond(eff_cond),
        .nest_err(nest_err)
    );

    function automatic bit ref_pass(int c, bit n, bit z, bit cf, bit v);
        case (c)
            0: return z;
            1: return !z;
            2: return n == v;
            3: return n != v;
            4: return !z && (n == v);
            5: return z || (n != v);
            6: return cf;
            default: return !cf;
        endcase
    endfunction

    task automatic check(string tag, string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s %s: actual=%0d expected=%0d at %0t",
                     req, tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive, compare against the model, clock, update the model.
    task automatic cyc(bit rv, bit st, int c, int cnt, bit [2:0] pat, bit iss,
                       bit [3:0] nzcv, string tag);
        int  ecnd;
        bit  eexec;
        @(negedge clk);
        rst_n = rv; it_start = st; it_cond = 3'(c); it_count = 2'(cnt);
        it_pattern = pat; issue = iss;
        {flag_n, flag_z, flag_c, flag_v} = nzcv;
        #(CLK_PERIOD/4);
        ecnd = m_cond;
        if (m_active && m_pos > 0 && m_pat[m_pos-1]) ecnd = m_cond ^ 1;
        eexec = !m_active || ref_pass(ecnd, nzcv[3], nzcv[2], nzcv[1], nzcv[0]);
        check(tag, "R1", "in_block", int'(in_block), int'(m_active));
        if (m_active)
            check(tag, (m_pos == 0) ? "R2" : "R3", "eff_cond", int'(eff_cond), ecnd);
        check(tag, m_active ? "R4" : "R5", "exec_en", int'(exec_en), int'(eexec));
        check(tag, "R8", "nest_err", int'(nest_err), int'(st && m_active));
        @(posedge clk);
        #1;
        if (!rv) begin
            m_active = 1'b0; m_pos = 0;
        end else if (st) begin
            m_active = 1'b1; m_pos = 0; m_len = cnt + 1; m_cond = c; m_pat = pat;
        end else if (m_active && iss) begin
            m_pos++;
            if (m_pos == m_len) begin m_active = 1'b0; m_pos = 0; end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R9: state after reset
        cyc(1, 0, 0, 0, 3'b000, 0, 4'b0000, "R9");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b0000, "R7");

        // R3: LT group, then-then-else-else, N!=V then N==V
        cyc(1, 1, 3, 3, 3'b110, 1, 4'b0000, "R10");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b1000, "R3");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b1000, "R3");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b1000, "R3");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b1000, "R3");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b1000, "R1");

        // R3: alternating mask on EQ
        cyc(1, 1, 0, 3, 3'b101, 0, 4'b0100, "R3");
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 3'b000, 1, 4'b0100, "R3");

        // R4: every code against every flag value, one-slot groups
        for (int c = 0; c < 8; c++)
            for (int f = 0; f < 16; f++) begin
                cyc(1, 1, c, 0, 3'b111, 0, 4'(f), "R4");
                cyc(1, 0, 0, 0, 3'b000, 1, 4'(f), "R4");
            end

        // R6: flags flip between slots of a GT group
        cyc(1, 1, 4, 2, 3'b000, 0, 4'b0000, "R6");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b0000, "R6");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b0100, "R6");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b1000, "R6");

        // R7: idle cycles inside a group hold the position
        cyc(1, 1, 6, 1, 3'b001, 0, 4'b0010, "R7");
        cyc(1, 0, 0, 0, 3'b000, 0, 4'b0010, "R7");
        cyc(1, 0, 0, 0, 3'b000, 0, 4'b0000, "R7");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b0010, "R7");
        cyc(1, 0, 0, 0, 3'b000, 0, 4'b0010, "R7");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b0000, "R7");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b0000, "R7");

        // R8: restart while open
        cyc(1, 1, 2, 3, 3'b111, 0, 4'b0000, "R8");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b0000, "R8");
        cyc(1, 1, 5, 1, 3'b001, 1, 4'b0100, "R8");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b0000, "R8");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b0000, "R8");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b0000, "R8");

        // R9: reset in mid-group
        cyc(1, 1, 1, 3, 3'b010, 1, 4'b0000, "R9");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b0000, "R9");
        cyc(0, 0, 0, 0, 3'b000, 0, 4'b0000, "R9");
        cyc(1, 0, 0, 0, 3'b000, 1, 4'b0000, "R9");

        // Random traffic against the model
        for (int i = 0; i < 3000; i++)
            cyc(($urandom % 64) != 0, ($urandom % 5) == 0, int'($urandom % 8),
                int'($urandom % 4), 3'($urandom), $urandom % 3 != 0,
                4'($urandom), "RND");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule